// File: doc/BRIEF.md
# I2C Line Conditioner and Condition Detector

This block is the front end of an I2C slave. It takes the raw clock and data pins and brings both into the system clock domain through a two-stage synchroniser. Each line then passes through a glitch filter, which accepts a new level only after that level has been held for longer than a programmable number of system cycles. From the two cleaned levels the block produces single-cycle strobes for START, STOP and the rising and falling edges of the clock line. It also keeps a flag that shows whether the bus is free.

On the return path, the protocol logic asks for the data line to be pulled low or released. The block passes that request to the pad enable. After each falling edge of the clock, it holds off any change for a programmable number of cycles. This keeps the slave's own data changes clear of the undefined part of the clock's falling edge, so that none of them can look like a START or a STOP. The pad is open-drain: the enable only pulls the line low, and a released line is pulled high by the external resistor.

The protocol engine uses the strobes to shift bits on clock edges and to reset its byte framing on every START.

Top module: `twi_line_cond`

## Requirements
- R1: After reset, `scl_lvl` and `sda_lvl` are 1, `bus_idle` is 1, `sda_pull_oe` is 0 and all four strobes are 0.
- R2: A pin level held for SPIKE_CYC+1 or more cycles appears on its filtered output. It appears more than SPIKE_CYC and at most SPIKE_CYC+3 clock cycles after the pin changes.
- R3: A pulse of SPIKE_CYC cycles or fewer on either pin leaves the filtered levels, the strobes and `bus_idle` unchanged.
- R4: `start_stb` is high for exactly one cycle when the filtered SDA goes from 1 to 0 while the filtered SCL is 1 before and after. This includes a START in the middle of a byte or while the bus is busy.
- R5: `stop_stb` is high for exactly one cycle when the filtered SDA goes from 0 to 1 while the filtered SCL stays 1.
- R6: `scl_rise` and `scl_fall` pulse for one cycle on each filtered SCL transition. At most one of the four strobes is high in any cycle.
- R7: `bus_idle` goes to 0 in the cycle after a START and to 1 in the cycle after a STOP. It is otherwise unchanged.
- R8: A change of SDA while SCL is low produces no START and no STOP.
- R9: After a filtered SCL falling edge, `sda_pull_oe` does not change for at least HOLD_CYC cycles. A request that is pending at that point takes effect no later than HOLD_CYC+3 cycles after the filtered edge is seen.
- R10: When no hold window is open, `sda_pull_oe` follows `sda_pull_req` one cycle later. A value of 1 means the line is pulled low; 0 means it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw clock pin level |
| sda_in | input | 1 | Raw data pin level |
| sda_pull_req | input | 1 | Protocol request: 1 = pull data low, 0 = release |
| scl_lvl | output | 1 | Filtered clock level |
| sda_lvl | output | 1 | Filtered data level |
| scl_rise | output | 1 | One-cycle strobe on a filtered clock rise |
| scl_fall | output | 1 | One-cycle strobe on a filtered clock fall |
| start_stb | output | 1 | One-cycle START strobe |
| stop_stb | output | 1 | One-cycle STOP strobe |
| bus_idle | output | 1 | 1 between a STOP (or reset) and the next START |
| sda_pull_oe | output | 1 | Open-drain pull-down enable for the data pad |

## Verification
The assertions assume that the raw pins are ordinary logic levels with no X. They also assume that `sda_pull_req` is driven by logic clocked by the same clock. The hold-window check counts only filtered SCL falls, so it takes for granted that the filter output is the timing reference.

The stimulus changes one pin at a time and leaves each change in place for well over the filter window before the next change. Deliberate spikes are the exception: their width is chosen on each side of SPIKE_CYC. Because of this, every clock and data change the bench makes maps to exactly one expected strobe, and the scoreboard can predict every event in order.

// File: rtl/twi_lc_pkg.sv
// Package for the I2C line conditioner.
// Holds the event strobe bundle and the line index constants.
package twi_lc_pkg;

    // Index of each line inside the two-bit pin vectors.
    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;
    localparam int N_LINES  = 2;

    // Single-cycle bus condition strobes.
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } twi_evt_t;

endpackage

// File: rtl/twi_sync2.sv
// Two-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; reset loads RST_VAL (released bus).
module twi_sync2 #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture the pins in two flops in a row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/twi_glitch_filt.sv
// Glitch filter for one synchronised line.
// The output takes a new level only after the input has differed from it
// for SPIKE_CYC+1 consecutive cycles. With SPIKE_CYC = 0 it is a plain register.
module twi_glitch_filt #(
    parameter int   SPIKE_CYC = 10,
    parameter logic RST_VAL   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int CW = (SPIKE_CYC > 0) ? $clog2(SPIKE_CYC + 1) : 1;

    generate
        if (SPIKE_CYC == 0) begin : g_bypass
            // No filtering: register the input.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= d;
            end
        end else begin : g_count
            logic [CW-1:0] run;

            // Count how long the input has disagreed; flip once the run is long enough.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q   <= RST_VAL;
                    run <= '0;
                end else if (d == q) begin
                    run <= '0;
                end else if (run == CW'(SPIKE_CYC)) begin
                    q   <= d;
                    run <= '0;
                end else begin
                    run <= run + 1'b1;
                end
            end
        end
    endgenerate

    AST_FILT_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (q != $past(q)) |-> ($past(d) == q)); // R2
endmodule

// File: rtl/twi_cond_detect.sv
// Bus condition detector working on the filtered levels.
// Produces the START, STOP and clock edge strobes and the bus-free flag.
// Assumes its inputs are already glitch-free and synchronous.
module twi_cond_detect
    import twi_lc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl,
    input  logic     sda,
    output twi_evt_t evt,
    output logic     bus_idle
);
    logic scl_d;
    logic sda_d;

    // Keep the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
        end
    end

    // Decode conditions: SDA edges only count while SCL is high on both sides.
    always_comb begin
        evt.start = scl & scl_d & sda_d & ~sda;
        evt.stop  = scl & scl_d & ~sda_d & sda;
        evt.rise  = scl & ~scl_d;
        evt.fall  = ~scl & scl_d;
    end

    // Bus-free flag: set by STOP, cleared by START.
    always_ff @(posedge clk) begin
        if (!rst_n)         bus_idle <= 1'b1;
        else if (evt.stop)  bus_idle <= 1'b1;
        else if (evt.start) bus_idle <= 1'b0;
    end

    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt.start, evt.stop, evt.rise, evt.fall})); // R6
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        evt.start |=> !bus_idle); // R7
    AST_STOP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stop |=> bus_idle); // R7
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt.start |=> !evt.start); // R4
endmodule

// File: rtl/twi_sda_hold.sv
// Data output hold stage.
// Passes the pull-low request to the pad enable, but freezes the enable for
// HOLD_CYC cycles after each filtered SCL fall. Assumes scl_fall is one cycle wide.
module twi_sda_hold #(
    parameter int HOLD_CYC = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_fall,
    input  logic req,
    output logic oe
);
    localparam int HW = (HOLD_CYC > 0) ? $clog2(HOLD_CYC + 1) : 1;

    generate
        if (HOLD_CYC == 0) begin : g_direct
            // No hold window: register the request.
            always_ff @(posedge clk) begin
                if (!rst_n) oe <= 1'b0;
                else        oe <= req;
            end
        end else begin : g_window
            logic [HW-1:0] wait_cnt;
            logic [HW-1:0] since_fall;

            // Open the window on a fall; update the enable only when it is closed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    oe       <= 1'b0;
                    wait_cnt <= '0;
                end else if (scl_fall) begin
                    wait_cnt <= HW'(HOLD_CYC);
                end else if (wait_cnt != '0) begin
                    wait_cnt <= wait_cnt - 1'b1;
                end else begin
                    oe <= req;
                end
            end

            // Independent saturating count of cycles since the last fall, used by the check.
            always_ff @(posedge clk) begin
                if (!rst_n)                         since_fall <= HW'(HOLD_CYC);
                else if (scl_fall)                  since_fall <= '0;
                else if (since_fall != HW'(HOLD_CYC)) since_fall <= since_fall + 1'b1;
            end

            AST_HOLD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
                (oe != $past(oe)) |-> (since_fall >= HW'(HOLD_CYC))); // R9
        end
    endgenerate
endmodule

// File: rtl/twi_line_cond.sv
// I2C line conditioner top.
// Synchronises and filters both pins, detects bus conditions, and applies
// the data output hold rule. Assumes the pads are open-drain with pull-ups.
module twi_line_cond
    import twi_lc_pkg::*;
#(
    parameter int SPIKE_CYC = 10,
    parameter int HOLD_CYC  = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic sda_pull_req,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_stb,
    output logic stop_stb,
    output logic bus_idle,
    output logic sda_pull_oe
);
    logic [N_LINES-1:0] raw_v;
    logic [N_LINES-1:0] sync_v;
    logic [N_LINES-1:0] filt_v;
    twi_evt_t           evt;

    // Gather the pins into one vector in line-index order.
    always_comb begin
        raw_v[LINE_SCL] = scl_in;
        raw_v[LINE_SDA] = sda_in;
    end

    twi_sync2 #(.W(N_LINES), .RST_VAL('1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_v), .q(sync_v)
    );

    generate
        for (genvar i = 0; i < N_LINES; i++) begin : g_filt
            twi_glitch_filt #(.SPIKE_CYC(SPIKE_CYC), .RST_VAL(1'b1)) u_filt (
                .clk(clk), .rst_n(rst_n), .d(sync_v[i]), .q(filt_v[i])
            );
        end
    endgenerate

    twi_cond_detect u_det (
        .clk(clk), .rst_n(rst_n),
        .scl(filt_v[LINE_SCL]), .sda(filt_v[LINE_SDA]),
        .evt(evt), .bus_idle(bus_idle)
    );

    twi_sda_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk(clk), .rst_n(rst_n), .scl_fall(evt.fall),
        .req(sda_pull_req), .oe(sda_pull_oe)
    );

    // Drive the outputs from the internal bundle.
    always_comb begin
        scl_lvl   = filt_v[LINE_SCL];
        sda_lvl   = filt_v[LINE_SDA];
        scl_rise  = evt.rise;
        scl_fall  = evt.fall;
        start_stb = evt.start;
        stop_stb  = evt.stop;
    end

    AST_FALL_FREEZES_OE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |=> (sda_pull_oe == $past(sda_pull_oe))); // R9
    AST_STOP_NEEDS_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        stop_stb |-> $past(scl_lvl)); // R5
endmodule

// File: tb/sim_twi_line_cond.sv
`timescale 1ns/1ps
module sim_twi_line_cond;
    localparam int SPIKE = 10;
    localparam int HOLD  = 60;
    localparam int SETTLE = SPIKE + 8;

    localparam int EV_START = 1;
    localparam int EV_STOP  = 2;
    localparam int EV_RISE  = 3;
    localparam int EV_FALL  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic sda_pull_req = 1'b0;
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_stb, stop_stb, bus_idle, sda_pull_oe;

    int checks = 0;
    int fails = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;
    logic scl_cur = 1'b1;
    logic sda_cur = 1'b1;
    int exp_q[$];

    always #2.5 clk = ~clk;

    twi_line_cond #(.SPIKE_CYC(SPIKE), .HOLD_CYC(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_pull_req(sda_pull_req), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_stb(start_stb),
        .stop_stb(stop_stb), .bus_idle(bus_idle), .sda_pull_oe(sda_pull_oe)
    );

    function automatic string req_of(int code);
        case (code)
            EV_START: return "R4";
            EV_STOP:  return "R5";
            default:  return "R6";
        endcase
    endfunction

    task automatic chk(bit ok, string rq, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, expv);
        end
    endtask

    // Scoreboard monitor: every strobe must match the next expected event.
    task automatic take(int code);
        int e;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL %s unexpected event (R3/R8) actual=%0d expected=%0d", req_of(code), code, 0);
        end else begin
            e = exp_q.pop_front();
            if (e != code) begin
                fails++;
                $display("FAIL %s event order actual=%0d expected=%0d", req_of(e), code, e);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            if (start_stb) take(EV_START);
            if (stop_stb)  take(EV_STOP);
            if (scl_rise)  take(EV_RISE);
            if (scl_fall)  take(EV_FALL);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver tasks: change a pin and push the event it must produce.
    task automatic drive_scl(logic v);
        if (v != scl_cur) exp_q.push_back(v ? EV_RISE : EV_FALL);
        scl_in = v;
        scl_cur = v;
        step(SETTLE);
    endtask

    task automatic drive_sda(logic v);
        if (v != sda_cur && scl_cur) exp_q.push_back(v ? EV_STOP : EV_START);
        sda_in = v;
        sda_cur = v;
        step(SETTLE);
    endtask

    task automatic bus_start();
        drive_sda(1'b0);
        drive_scl(1'b0);
    endtask

    task automatic bus_stop();
        drive_sda(1'b0);
        drive_scl(1'b1);
        drive_sda(1'b1);
    endtask

    task automatic send_bits(logic [7:0] b, int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            drive_sda(b[i]);
            drive_scl(1'b1);
            drive_scl(1'b0);
        end
    endtask

    // Spike on one line (0 = SCL, 1 = SDA) of the given width; no event expected.
    task automatic spike(int line, int width, string rq);
        int bad = 0;
        logic ref_l;
        logic ref_idle;
        ref_l = line ? sda_lvl : scl_lvl;
        ref_idle = bus_idle;
        if (line) sda_in = ~sda_cur; else scl_in = ~scl_cur;
        for (int k = 0; k < width; k++) begin
            @(negedge clk);
            if ((line ? sda_lvl : scl_lvl) != ref_l || bus_idle != ref_idle) bad++;
        end
        if (line) sda_in = sda_cur; else scl_in = scl_cur;
        for (int k = 0; k < SETTLE; k++) begin
            @(negedge clk);
            if ((line ? sda_lvl : scl_lvl) != ref_l || bus_idle != ref_idle) bad++;
        end
        chk(bad == 0, rq, "spike changed level or idle (cycles)", bad, 0);
    endtask

    initial begin
        int n;
        int m;
        step(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(scl_lvl == 1'b1, "R1", "scl_lvl after reset", scl_lvl, 1);
        chk(sda_lvl == 1'b1, "R1", "sda_lvl after reset", sda_lvl, 1);
        chk(bus_idle == 1'b1, "R1", "bus_idle after reset", bus_idle, 1);
        chk(sda_pull_oe == 1'b0, "R1", "sda_pull_oe after reset", sda_pull_oe, 0);
        chk({start_stb, stop_stb, scl_rise, scl_fall} == 4'b0, "R1", "strobes after reset",
            {start_stb, stop_stb, scl_rise, scl_fall}, 0);
        mon_en = 1'b1;
        step(SETTLE);

        // R3: spikes of SPIKE cycles on each line while idle
        spike(0, SPIKE, "R3");
        spike(1, SPIKE, "R3");
        spike(1, 1, "R3");

        // R2: SDA pulse one cycle longer than the window is seen as START then STOP
        exp_q.push_back(EV_START);
        exp_q.push_back(EV_STOP);
        sda_in = 1'b0;
        step(SPIKE + 1);
        sda_in = 1'b1;
        step(2 * SETTLE);
        chk(bus_idle == 1'b1, "R7", "idle after accepted pulse", bus_idle, 1);

        // R4/R7/R8: frame with data bits
        bus_start();
        chk(bus_idle == 1'b0, "R7", "idle after START", bus_idle, 0);
        send_bits(8'hA5, 8);
        send_bits(8'h3C, 8);
        chk(bus_idle == 1'b0, "R8", "idle during data", bus_idle, 0);
        // R3: spike on SCL while low mid-frame
        spike(0, SPIKE, "R3");
        // R4: repeated START after three bits
        send_bits(8'hE0, 3);
        drive_sda(1'b1);
        drive_scl(1'b1);
        drive_sda(1'b0);
        chk(bus_idle == 1'b0, "R7", "idle after repeated START", bus_idle, 0);
        drive_scl(1'b0);
        send_bits(8'h5A, 8);
        bus_stop();
        chk(bus_idle == 1'b1, "R7", "idle after STOP", bus_idle, 1);

        // Hold window tests
        bus_start();
        step(HOLD + 5);
        sda_pull_req = 1'b1;
        @(negedge clk);
        chk(sda_pull_oe == 1'b1, "R10", "oe follows request with window closed", sda_pull_oe, 1);
        drive_scl(1'b1);
        // R2: latency of the SCL fall, R9: hold of the release
        exp_q.push_back(EV_FALL);
        scl_in = 1'b0;
        scl_cur = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (scl_lvl != 1'b0 && n < 4 * SPIKE);
        chk(n > SPIKE && n <= SPIKE + 3, "R2", "filter latency cycles", n, SPIKE + 3);
        sda_pull_req = 1'b0;
        m = 0;
        do begin
            @(negedge clk);
            m++;
        end while (sda_pull_oe != 1'b0 && m < HOLD + 10);
        chk(m >= HOLD, "R9", "oe change too early after fall", m, HOLD);
        chk(m <= HOLD + 3, "R9", "oe change too late after fall", m, HOLD + 3);
        sda_pull_req = 1'b1;
        @(negedge clk);
        chk(sda_pull_oe == 1'b1, "R10", "oe re-asserts one cycle after request", sda_pull_oe, 1);
        sda_pull_req = 1'b0;
        @(negedge clk);
        chk(sda_pull_oe == 1'b0, "R10", "oe releases one cycle after request", sda_pull_oe, 0);
        step(SETTLE);
        bus_stop();
        step(SETTLE);

        chk(exp_q.size() == 0, "R6", "expected events left over", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R1-watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule